// File: doc/BRIEF.md
# Serially Configured Lookup Table Cell

This block is one programmable logic cell. Its function is set entirely by a serial bitstream. The cell holds a 3-input lookup table and a small array of switches. Each switch can join one horizontal (row) wire to one vertical (column) wire. Every configuration bit of the cell, for the table and for the switches, is one flip-flop in a single shift register. The bits enter on one data pin, one bit per rising edge of the configuration clock, and only while the shift-enable input is high. When shifting is idle, the stored function stays fixed.

The table output is the stored bit chosen by the three select inputs. Each switch whose bit is 1 passes a row wire's value onto its column wire, and a column wire's value onto its row wire. The last flip-flop of the chain drives a serial output, so several cells can be placed in one long configuration chain. Reset clears every configuration bit at once. The reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `cfg_lut_cell`

## Requirements
- R1: While `rst_n` is low, every configuration bit is 0. This shows at the ports as `lut_out`, `row_out`, `col_out` and `cfg_dout` all 0, whatever the other inputs are.
- R2: At a rising edge of `cfg_clk` with `cfg_en` high (after reset release), the chain moves one place toward the far end. `cfg_din` enters at the near end.
- R3: At a rising edge with `cfg_en` low, no configuration bit changes, whatever value `cfg_din` has.
- R4: Frame position k is the bit that sits k places from the far end after a full frame of 8 + ROWS*COLS bits has been shifted in. Positions 0 to 7 are the table bits, so the first bit shifted in becomes table entry 0.
- R5: `lut_out` equals the table bit at position `lut_in`, with `lut_in` read as an unsigned number from 0 to 7.
- R6: The switch for row r and column c sits at frame position 8 + r*COLS + c. A value of 1 closes that crossing and a value of 0 leaves it open.
- R7: Bit c of `col_out` is the OR, over all rows r whose switch to column c is closed, of `row_in[r]`. It is 0 when no switch in that column is closed.
- R8: Bit r of `row_out` is the OR, over all columns c whose switch to row r is closed, of `col_in[c]`. It is 0 when no switch in that row is closed.
- R9: `cfg_dout` shows the bit at frame position 0. Shifting therefore passes the previous contents out in the order in which they were loaded.
- R10: After `rst_n` rises, the first two rising edges of `cfg_clk` shift nothing even when `cfg_en` is high. The third edge is the first that can shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial data out from the far end of the chain |
| lut_in | input | 3 | Lookup table select inputs |
| lut_out | output | 1 | Lookup table output |
| row_in | input | ROWS | Values driven onto the row wires |
| col_in | input | COLS | Values driven onto the column wires |
| row_out | output | ROWS | Row wire values received through closed switches |
| col_out | output | COLS | Column wire values received through closed switches |

## Verification
The checker watches three things on every clock: the shift motion, the new bit entering at the near end, and the hold when shifting is idle. It also checks that the serial output follows the chain, that the table output follows the stored bits, and that the chain is cleared while the synchronized reset is active. Some behaviours are only visible in the bench scenarios, where a behavioural model compares all outputs on every clock. These are the frame-position mapping of table and switch bits, the OR behaviour of several closed switches on one wire, the two dead edges after reset release, and an asynchronous reset arriving in the middle of a load.

// File: rtl/cfg_lut_pkg.sv
package cfg_lut_pkg;
  // Number of table entries for a K-input lookup table.
  function automatic int unsigned table_size(input int unsigned k);
    return 32'd1 << k;
  endfunction

  // Frame position of the switch at (row, col), counted after the table bits.
  function automatic int unsigned switch_pos(input int unsigned row,
                                             input int unsigned col,
                                             input int unsigned cols);
    return row * cols + col;
  endfunction
endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= '0;
    else         stage_q <= stage_d;
  end

  assign srst_n = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_shift_chain.sv
module cfg_shift_chain #(
  parameter int unsigned LEN = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           din,
  output logic [LEN-1:0] bits,
  output logic           dout
);
  logic [LEN-1:0] chain_q;
  logic [LEN-1:0] chain_d;

  // Index LEN-1 is the entry end, index 0 the far end.
  always_comb begin
    chain_d = chain_q;
    if (shift_en) chain_d = {din, chain_q[LEN-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign bits = chain_q;
  assign dout = chain_q[0];
endmodule

// File: rtl/lut_select.sv
module lut_select #(
  parameter int unsigned K = 3,
  localparam int unsigned ENTRIES = 1 << K
) (
  input  logic [ENTRIES-1:0] table_bits,
  input  logic [K-1:0]       sel,
  output logic               y
);
  always_comb begin
    y = table_bits[sel];
  end
endmodule

// File: rtl/xbar_switch.sv
module xbar_switch #(
  parameter int unsigned ROWS = 2,
  parameter int unsigned COLS = 3,
  localparam int unsigned NSW = ROWS * COLS
) (
  input  logic [NSW-1:0]  sw_bits,
  input  logic [ROWS-1:0] row_in,
  input  logic [COLS-1:0] col_in,
  output logic [ROWS-1:0] row_out,
  output logic [COLS-1:0] col_out
);
  import cfg_lut_pkg::*;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [ROWS-1:0] hits;
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign hits[r] = row_in[r] & sw_bits[switch_pos(r, c, COLS)];
    end
    assign col_out[c] = |hits;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_rowo
    logic [COLS-1:0] hits;
    for (genvar c = 0; c < COLS; c++) begin : g_c
      assign hits[c] = col_in[c] & sw_bits[switch_pos(r, c, COLS)];
    end
    assign row_out[r] = |hits;
  end
endmodule

// File: rtl/cfg_lut_cell.sv
module cfg_lut_cell #(
  parameter int unsigned K    = 3,
  parameter int unsigned ROWS = 2,
  parameter int unsigned COLS = 3
) (
  input  logic            cfg_clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic            cfg_din,
  output logic            cfg_dout,
  input  logic [K-1:0]    lut_in,
  output logic            lut_out,
  input  logic [ROWS-1:0] row_in,
  input  logic [COLS-1:0] col_in,
  output logic [ROWS-1:0] row_out,
  output logic [COLS-1:0] col_out
);
  import cfg_lut_pkg::*;

  localparam int unsigned TBITS = table_size(K);
  localparam int unsigned NSW   = ROWS * COLS;
  localparam int unsigned CLEN  = TBITS + NSW;

  logic            rst_sync_n;
  logic [CLEN-1:0] cfg_bits;

  cfg_rst_sync #(.STAGES(2)) u_rst (
    .clk    (cfg_clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  cfg_shift_chain #(.LEN(CLEN)) u_chain (
    .clk      (cfg_clk),
    .rst_n    (rst_sync_n),
    .shift_en (cfg_en),
    .din      (cfg_din),
    .bits     (cfg_bits),
    .dout     (cfg_dout)
  );

  lut_select #(.K(K)) u_lut (
    .table_bits (cfg_bits[TBITS-1:0]),
    .sel        (lut_in),
    .y          (lut_out)
  );

  xbar_switch #(.ROWS(ROWS), .COLS(COLS)) u_xbar (
    .sw_bits (cfg_bits[CLEN-1:TBITS]),
    .row_in  (row_in),
    .col_in  (col_in),
    .row_out (row_out),
    .col_out (col_out)
  );
endmodule

// File: rtl/cfg_lut_cell_chk.sv
module cfg_lut_cell_chk #(
  parameter int unsigned K    = 3,
  parameter int unsigned CLEN = 14
) (
  input logic            cfg_clk,
  input logic            rst_n,
  input logic            rst_sync_n,
  input logic            cfg_en,
  input logic            cfg_din,
  input logic            cfg_dout,
  input logic [K-1:0]    lut_in,
  input logic            lut_out,
  input logic [CLEN-1:0] cfg_bits
);
  // R1
  cleared_in_reset_chk: assert property (@(posedge cfg_clk)
    !rst_sync_n |-> cfg_bits == '0);

  // R2
  entry_bit_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (cfg_en && rst_sync_n) |=> cfg_bits[CLEN-1] == $past(cfg_din));

  // R2
  shift_motion_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (cfg_en && rst_sync_n) |=> cfg_bits[CLEN-2:0] == $past(cfg_bits[CLEN-1:1]));

  // R3
  idle_hold_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (!cfg_en && rst_sync_n) |=> $stable(cfg_bits));

  // R9
  serial_out_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (cfg_en && rst_sync_n) |=> cfg_dout == $past(cfg_bits[1]));

  // R5
  table_pick_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    lut_out == cfg_bits[lut_in]);
endmodule

bind cfg_lut_cell cfg_lut_cell_chk #(.K(K), .CLEN(CLEN)) u_chk (
  .cfg_clk    (cfg_clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .cfg_en     (cfg_en),
  .cfg_din    (cfg_din),
  .cfg_dout   (cfg_dout),
  .lut_in     (lut_in),
  .lut_out    (lut_out),
  .cfg_bits   (cfg_bits)
);

// File: tb/test_cfg_lut_cell.sv
module test_cfg_lut_cell;
  localparam int K = 3;
  localparam int ROWS = 2;
  localparam int COLS = 3;
  localparam int TB = 8;
  localparam int N = TB + ROWS * COLS;

  logic cfg_clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0;
  logic cfg_din = 1'b0;
  logic cfg_dout;
  logic [K-1:0] lut_in = '0;
  logic lut_out;
  logic [ROWS-1:0] row_in = '0;
  logic [COLS-1:0] col_in = '0;
  logic [ROWS-1:0] row_out;
  logic [COLS-1:0] col_out;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  string phase = "R1 reset";

  always #10 cfg_clk = ~cfg_clk;

  cfg_lut_cell #(.K(K), .ROWS(ROWS), .COLS(COLS)) i_cfg_lut_cell (
    .cfg_clk(cfg_clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .cfg_dout(cfg_dout), .lut_in(lut_in), .lut_out(lut_out),
    .row_in(row_in), .col_in(col_in), .row_out(row_out), .col_out(col_out));

  // Behavioural model: queue element 0 is frame position 0 (far end).
  bit mq[$];
  int since_rel = 0;

  initial for (int i = 0; i < N; i++) mq.push_back(1'b0);

  always @(posedge cfg_clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mq[i] = 1'b0;
      since_rel = 0;
    end else begin
      if (since_rel >= 2 && cfg_en) begin   // R10: two dead edges
        mq.push_back(cfg_din);              // R2
        void'(mq.pop_front());
      end
      if (since_rel < 2) since_rel++;
    end
  end

  function automatic bit sw(int r, int c);
    return mq[TB + r * COLS + c];           // R6 frame position
  endfunction

  task automatic chk1(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [COLS-1:0] ec;
    logic [ROWS-1:0] er;
    ec = '0;
    er = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        if (sw(r, c) && row_in[r]) ec[c] = 1'b1;
        if (sw(r, c) && col_in[c]) er[r] = 1'b1;
      end
    chk1("R5 lut_out", lut_out, mq[lut_in]);
    chk1("R7 col_out", col_out, ec);
    chk1("R8 row_out", row_out, er);
    chk1("R9 cfg_dout", cfg_dout, mq[0]);
  endtask

  task automatic tick_rand_io();
    @(negedge cfg_clk);
    compare_all();
    lut_in = K'($urandom);
    row_in = ROWS'($urandom);
    col_in = COLS'($urandom);
  endtask

  task automatic shift_frame(input bit fr[N]);
    for (int i = 0; i < N; i++) begin
      @(negedge cfg_clk);
      compare_all();
      cfg_en = 1'b1;
      cfg_din = fr[i];
    end
    @(negedge cfg_clk);
    compare_all();
    cfg_en = 1'b0;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    bit fr[N];
    // R1: outputs cleared in reset, all inputs driven high
    lut_in = '1; row_in = '1; col_in = '1; cfg_en = 1'b1; cfg_din = 1'b1;
    repeat (3) begin @(negedge cfg_clk); compare_all(); end
    // R10: release with shifting requested; first two edges do nothing
    phase = "R10 release";
    rst_n = 1'b1;
    repeat (4) begin @(negedge cfg_clk); compare_all(); end
    cfg_en = 1'b0;
    // R2 R4 R6: known frame - table is 3-input XOR, diagonal switches
    phase = "R2 R4 R6 load";
    for (int i = 0; i < N; i++) fr[i] = 1'b0;
    for (int i = 0; i < TB; i++) fr[i] = ^(3'(i));
    fr[TB + 0] = 1'b1;                    // row0-col0
    fr[TB + COLS + 1] = 1'b1;             // row1-col1
    fr[TB + COLS + 2] = 1'b1;             // row1-col2
    shift_frame(fr);
    // R3: idle with cfg_din toggling
    phase = "R3 idle";
    for (int i = 0; i < 12; i++) begin
      @(negedge cfg_clk);
      compare_all();
      cfg_din = ~cfg_din;
    end
    // R5 R7 R8: exhaustive input sweep
    phase = "R5 R7 R8 sweep";
    for (int v = 0; v < 256; v++) begin
      @(negedge cfg_clk);
      compare_all();
      {lut_in, row_in, col_in} = 8'(v);
    end
    // R9: random frames push previous contents out in load order
    phase = "R9 R2 random frames";
    for (int f = 0; f < 6; f++) begin
      for (int i = 0; i < N; i++) fr[i] = 1'($urandom);
      shift_frame(fr);
      repeat (20) tick_rand_io();
    end
    // R7 R8: all switches closed
    phase = "R7 R8 full mesh";
    for (int i = 0; i < N; i++) fr[i] = 1'b1;
    shift_frame(fr);
    repeat (40) tick_rand_io();
    // R1: asynchronous reset in the middle of a load
    phase = "R1 async reset";
    for (int i = 0; i < 5; i++) begin
      @(negedge cfg_clk); compare_all(); cfg_en = 1'b1; cfg_din = 1'b1;
    end
    #5 rst_n = 1'b0;
    #2 compare_all();
    @(negedge cfg_clk); compare_all();
    rst_n = 1'b1;
    phase = "R10 second release";
    repeat (8) begin @(negedge cfg_clk); compare_all(); cfg_din = 1'($urandom); end
    cfg_en = 1'b0;
    @(negedge cfg_clk); compare_all();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule